// File: doc/BRIEF.md
# Oscillator Calibration Counter and Watchdog Tick Divider

This block checks a slow on-chip oscillator against a fast reference clock and produces a slow 10 Hz tick for a watchdog timer. Software starts a measurement through a small register window. The block waits for a rising edge of the slow oscillator. It then counts reference-clock cycles until ten more slow periods have passed. The final count is kept in a 16-bit result register until the next measurement completes. A nominal pairing of 48 MHz against 500 kHz gives about 960.

The same window holds a 12-bit divisor. The divider counts rising edges of a 10 kHz tick, which is synchronous to the reference clock, and emits one output pulse per divisor-plus-one edges. A bank-select input decides how two of the indices behave. With the bank set, they give divisor and count access. With it clear, they reach an unrelated reserved byte and a pin-function select register. The slow oscillator input is asynchronous and passes through a two-flop synchronizer. Reads are combinational on the selected index. Writes take effect at the clock edge where the write strobe is high.

Top module: `clk_tune_unit`

## Requirements
- R1: With the bank set, writing index 0x29 with bit 7 = 1 starts a measurement. `busy_o` is high at the second rising clock edge after the write edge.
- R2: When the slow oscillator's synchronized rising edges are exactly P reference cycles apart, the result equals 10*P. This is the count over ten slow periods that begin at the first slow edge after the start.
- R3: `busy_o` stays high until the result is latched. While a measurement runs, the result registers keep the previous completed value.
- R4: A start write during a running measurement is ignored. The window already in progress ends at its original time.
- R5: The running count saturates at 0xFFFF. A window stretched by a stalled oscillator reports 0xFFFF.
- R6: With the bank set, reads of index 0x2A return result bits [7:0] and reads of 0x2B return bits [15:8]. Writes to 0x2B are ignored.
- R7: The divisor is 12 bits and resets to 0x3E7. Its high nibble is written through index 0x29 bits [3:0] and its low byte through index 0x2A, both with the bank set. Index 0x29 reads as {4'b0, high nibble}: bit 7 reads 0, and bits [6:4] read 0 and ignore writes.
- R8: `tick_10hz_o` is a one-cycle pulse. It goes high in the cycle after every (divisor+1)-th rising edge of `tick_10k_i`.
- R9: With the bank clear, index 0x2A is an 8-bit read/write byte that resets to 0x00. Index 0x2B is a pin-select byte that resets to 0x02, with bits [4:2] reading 0. Index 0x29 reads 0 in this bank, and writes to it start nothing and leave the divisor unchanged.
- R10: After reset, `busy_o` and `tick_10hz_o` are 0 and the result is 0.

Clock domain and ordering note: all register state is in the `clk` domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_en_i | input | 1 | Bank select: 1 = divisor/count access, 0 = reserved/pin-select |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 8 | Register index for reads and writes |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the indexed register (combinational) |
| slow_osc_i | input | 1 | Slow oscillator under measurement (asynchronous) |
| tick_10k_i | input | 1 | 10 kHz tick, synchronous to clk |
| tick_10hz_o | output | 1 | Divided watchdog tick pulse |
| busy_o | output | 1 | Measurement in progress |

## Verification
`busy_o` rises two edges after a start write: one edge registers the start and one changes the measurement state. The bench samples it at the falling edge after that. A result is due only when `busy_o` falls. The bench polls for that fall against a cycle bound of 11 slow periods plus synchronizer latency, which a restarted window would exceed. Divider pulses appear one cycle after the edge that completes a divisor period. A scoreboard model records the number of the tick edge at which each pulse is due. The monitor compares every observed pulse against that edge count at the next falling edge.

// File: rtl/ctu_pkg.sv
package ctu_pkg;

    typedef enum logic [1:0] {
        MS_IDLE  = 2'd0,
        MS_ARM   = 2'd1,
        MS_COUNT = 2'd2
    } meas_st_e;

    typedef struct packed {
        logic       we;
        logic [7:0] idx;
        logic [7:0] wdata;
    } bus_wr_t;

endpackage

// File: rtl/ctu_regs.sv
module ctu_regs #(
    parameter int          DIV_W       = 12,
    parameter int          CNT_W       = 16,
    parameter logic [11:0] DIV_RST     = 12'h3E7,
    parameter logic [7:0]  PINSEL_RST  = 8'h02,
    parameter logic [7:0]  PINSEL_MASK = 8'hE3,
    parameter logic [7:0]  IDX_CTRL    = 8'h29,
    parameter logic [7:0]  IDX_LO      = 8'h2A,
    parameter logic [7:0]  IDX_HI      = 8'h2B
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bank_i,
    input  ctu_pkg::bus_wr_t      wr_i,
    input  logic [CNT_W-1:0]      count_i,
    output logic [7:0]            rdata_o,
    output logic [DIV_W-1:0]      div_o,
    output logic                  start_o
);
    localparam int HI_W = DIV_W - 8;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [7:0]       rsvd;
        logic [7:0]       pinsel;
        logic             start;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (wr_i.we) begin
            if (bank_i) begin
                if (wr_i.idx == IDX_CTRL) begin
                    st_d.div[DIV_W-1:8] = wr_i.wdata[HI_W-1:0];
                    st_d.start          = wr_i.wdata[7];
                end else if (wr_i.idx == IDX_LO) begin
                    st_d.div[7:0] = wr_i.wdata;
                end
            end else begin
                if (wr_i.idx == IDX_LO) begin
                    st_d.rsvd = wr_i.wdata;
                end else if (wr_i.idx == IDX_HI) begin
                    st_d.pinsel = wr_i.wdata & PINSEL_MASK;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.div    <= DIV_RST[DIV_W-1:0];
            st_q.rsvd   <= 8'h00;
            st_q.pinsel <= PINSEL_RST & PINSEL_MASK;
            st_q.start  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = 8'h00;
        if (bank_i) begin
            if (wr_i.idx == IDX_CTRL)    rdata_o = {{(8-HI_W){1'b0}}, st_q.div[DIV_W-1:8]};
            else if (wr_i.idx == IDX_LO) rdata_o = count_i[7:0];
            else if (wr_i.idx == IDX_HI) rdata_o = count_i[15:8];
        end else begin
            if (wr_i.idx == IDX_LO)      rdata_o = st_q.rsvd;
            else if (wr_i.idx == IDX_HI) rdata_o = st_q.pinsel;
        end
    end

    assign div_o   = st_q.div;
    assign start_o = st_q.start;

    // start pulse only from a bank-1 control write with bit 7 set
    assert_start_decode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(wr_i.we && bank_i && wr_i.idx == IDX_CTRL && wr_i.wdata[7]));

    // divisor untouched while the bank is clear
    assert_bank0_div_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_i |=> $stable(div_o));

endmodule

// File: rtl/ctu_meas.sv
module ctu_meas #(
    parameter int CNT_W     = 16,
    parameter int WIN_EDGES = 10,
    parameter int SYNC_N    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_i,
    input  logic             start_i,
    output logic             busy_o,
    output logic [CNT_W-1:0] result_o
);
    import ctu_pkg::*;

    localparam int             EW      = $clog2(WIN_EDGES);
    localparam logic [EW-1:0]  LAST_E  = EW'(WIN_EDGES - 1);
    localparam logic [CNT_W-1:0] CMAX  = '1;

    typedef struct packed {
        logic [SYNC_N:0]  sync;
        meas_st_e         st;
        logic [EW-1:0]    edges;
        logic [CNT_W-1:0] run;
        logic [CNT_W-1:0] result;
    } meas_t;

    meas_t m_d, m_q;
    logic  slow_edge;
    logic  done;
    logic [CNT_W-1:0] run_inc;

    assign slow_edge = m_q.sync[SYNC_N-1] & ~m_q.sync[SYNC_N];
    assign run_inc   = (m_q.run == CMAX) ? CMAX : m_q.run + 1'b1;
    assign done      = (m_q.st == MS_COUNT) && slow_edge && (m_q.edges == LAST_E);

    always_comb begin
        m_d      = m_q;
        m_d.sync = {m_q.sync[SYNC_N-1:0], slow_i};
        unique case (m_q.st)
            MS_IDLE: begin
                if (start_i) m_d.st = MS_ARM;
            end
            MS_ARM: begin
                if (slow_edge) begin
                    m_d.st    = MS_COUNT;
                    m_d.run   = '0;
                    m_d.edges = '0;
                end
            end
            MS_COUNT: begin
                m_d.run = run_inc;
                if (done) begin
                    m_d.result = run_inc;
                    m_d.st     = MS_IDLE;
                end else if (slow_edge) begin
                    m_d.edges = m_q.edges + 1'b1;
                end
            end
            default: m_d.st = MS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q.sync   <= '0;
            m_q.st     <= MS_IDLE;
            m_q.edges  <= '0;
            m_q.run    <= '0;
            m_q.result <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign busy_o   = (m_q.st != MS_IDLE);
    assign result_o = m_q.result;

    assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    assert_result_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(result_o));

    assert_restart_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.st == MS_COUNT && start_i && !done) |=> (m_q.st == MS_COUNT));

    assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.st == MS_COUNT && m_q.run == CMAX && !done) |=> (m_q.run == CMAX));

endmodule

// File: rtl/ctu_div.sv
module ctu_div #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             pulse_o
);
    typedef struct packed {
        logic             prev;
        logic [DIV_W-1:0] cnt;
        logic             pulse;
    } div_t;

    div_t v_d, v_q;
    logic tick_edge;

    assign tick_edge = tick_i & ~v_q.prev;

    always_comb begin
        v_d       = v_q;
        v_d.prev  = tick_i;
        v_d.pulse = 1'b0;
        if (tick_edge) begin
            if (v_q.cnt >= div_i) begin
                v_d.cnt   = '0;
                v_d.pulse = 1'b1;
            end else begin
                v_d.cnt = v_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= '0;
        end else begin
            v_q <= v_d;
        end
    end

    assign pulse_o = v_q.pulse;

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

    assert_pulse_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(tick_i));

endmodule

// File: rtl/clk_tune_unit.sv
module clk_tune_unit #(
    parameter int          DIV_W     = 12,
    parameter int          CNT_W     = 16,
    parameter int          WIN_EDGES = 10,
    parameter int          SYNC_N    = 2,
    parameter logic [11:0] DIV_RST   = 12'h3E7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog_en_i,
    input  logic       reg_we_i,
    input  logic [7:0] reg_idx_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    input  logic       slow_osc_i,
    input  logic       tick_10k_i,
    output logic       tick_10hz_o,
    output logic       busy_o
);
    import ctu_pkg::*;

    bus_wr_t          wr;
    logic [CNT_W-1:0] result;
    logic [DIV_W-1:0] divisor;
    logic             start;

    assign wr = '{we: reg_we_i, idx: reg_idx_i, wdata: reg_wdata_i};

    ctu_regs #(
        .DIV_W   (DIV_W),
        .CNT_W   (CNT_W),
        .DIV_RST (DIV_RST)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .bank_i  (prog_en_i),
        .wr_i    (wr),
        .count_i (result),
        .rdata_o (reg_rdata_o),
        .div_o   (divisor),
        .start_o (start)
    );

    ctu_meas #(
        .CNT_W     (CNT_W),
        .WIN_EDGES (WIN_EDGES),
        .SYNC_N    (SYNC_N)
    ) u_meas (
        .clk      (clk),
        .rst_n    (rst_n),
        .slow_i   (slow_osc_i),
        .start_i  (start),
        .busy_o   (busy_o),
        .result_o (result)
    );

    ctu_div #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_10k_i),
        .div_i   (divisor),
        .pulse_o (tick_10hz_o)
    );

endmodule

// File: tb/clk_tune_unit_test.sv
module clk_tune_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_en = 1'b1;
    logic       we = 1'b0;
    logic [7:0] idx = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       slow = 1'b0;
    logic       tick = 1'b0;
    logic       p10;
    logic       busy;

    int checks = 0;
    int errors = 0;
    int half = 8;
    int stall = 0;
    int edges_sent = 0;
    int mdiv = 12'h3E7;
    int mcnt = 0;
    int pulse_q[$];
    bit done_flag = 0;

    always #4 clk = ~clk;

    clk_tune_unit uut (
        .clk(clk), .rst_n(rst_n), .prog_en_i(prog_en), .reg_we_i(we),
        .reg_idx_i(idx), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .slow_osc_i(slow), .tick_10k_i(tick), .tick_10hz_o(p10), .busy_o(busy)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] i, logic [7:0] d);
        @(negedge clk);
        we = 1'b1; idx = i; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [7:0] i, output int v);
        @(negedge clk);
        idx = i;
        #1 v = rdata;
    endtask

    // driver: sends tick edges and pushes expected pulse edge numbers
    task automatic send_ticks(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            edges_sent++;
            tick = 1'b1;
            if (mcnt >= mdiv) begin
                mcnt = 0;
                pulse_q.push_back(edges_sent);
            end else begin
                mcnt++;
            end
            @(negedge clk);
            tick = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_idle(int limit, output int cyc);
        cyc = 0;
        while (busy && cyc < limit) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    // monitor: pops expected pulses as the design produces them
    always @(negedge clk) begin
        if (rst_n && p10) begin
            checks++;
            if (pulse_q.size() == 0) begin
                errors++;
                $display("FAIL R8: actual=pulse at edge %0d expected=no pulse", edges_sent);
            end else begin
                int e;
                e = pulse_q.pop_front();
                if (e != edges_sent) begin
                    errors++;
                    $display("FAIL R8: actual=edge %0d expected=edge %0d", edges_sent, e);
                end
            end
        end
    end

    // slow oscillator model, period 2*half reference cycles
    initial begin
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            if (stall == 0) begin
                ph++;
                if (ph >= half) begin
                    ph = 0;
                    slow = ~slow;
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int v;
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 busy", int'(busy), 0);
        chk("R10 pulse", int'(p10), 0);
        rd(8'h2A, v); chk("R10 count lo", v, 0);
        rd(8'h2B, v); chk("R10 count hi", v, 0);
        rd(8'h29, v); chk("R7 reset div hi", v, 8'h03);
        prog_en = 1'b0;
        rd(8'h2A, v); chk("R9 reset rsvd", v, 8'h00);
        rd(8'h2B, v); chk("R9 reset pinsel", v, 8'h02);
        rd(8'h29, v); chk("R9 idx29 bank0", v, 8'h00);
        prog_en = 1'b1;

        // R8/R7 default divisor: pulse after 1000 edges
        send_ticks(1000);
        chk("R7 default period", pulse_q.size(), 0);

        // R7 reserved bits, then divisor 4
        wr(8'h29, 8'h7F);
        rd(8'h29, v); chk("R7 bits6:4 read 0", v, 8'h0F);
        wr(8'h29, 8'h00);
        wr(8'h2A, 8'h04);
        mdiv = 4;
        rd(8'h29, v); chk("R7 div hi", v, 8'h00);
        chk("R1 no start on bit7=0", int'(busy), 0);
        send_ticks(15);
        chk("R8 div4 pulses", pulse_q.size(), 0);

        // R9 bank 0 registers
        prog_en = 1'b0;
        wr(8'h2A, 8'h5A);
        wr(8'h2B, 8'hFF);
        wr(8'h29, 8'h8F);
        repeat (2) @(negedge clk);
        chk("R9 no start bank0", int'(busy), 0);
        rd(8'h2A, v); chk("R9 rsvd rw", v, 8'h5A);
        rd(8'h2B, v); chk("R9 pinsel mask", v, 8'hE3);
        prog_en = 1'b1;
        rd(8'h29, v); chk("R9 div hi untouched", v, 8'h00);
        rd(8'h2A, v); chk("R9 count unaffected", v, 8'h00);
        send_ticks(5);
        chk("R9 div low untouched", pulse_q.size(), 0);

        // R1/R2/R3 measurement at P=16
        half = 8;
        wr(8'h29, 8'h80);
        @(negedge clk);
        chk("R1 busy after start", int'(busy), 1);
        rd(8'h29, v); chk("R7 bit7 reads 0", v, 8'h00);
        rd(8'h2A, v); chk("R3 old result held", v, 8'h00);
        chk("R3 busy during window", int'(busy), 1);
        wait_idle(400, cyc);
        chk("R3 busy falls", int'(busy), 0);
        rd(8'h2A, v); chk("R2 count lo P16", v, 8'hA0);
        rd(8'h2B, v); chk("R6 count hi P16", v, 8'h00);

        // R4 restart ignored
        wr(8'h29, 8'h80);
        repeat (80) @(negedge clk);
        wr(8'h29, 8'h80);
        wait_idle(400, cyc);
        chk("R4 window not restarted", int'(cyc + 83 <= 11 * 16 + 8), 1);
        rd(8'h2A, v); chk("R4 count", v, 8'hA0);

        // R2 second period P=24
        half = 12;
        repeat (30) @(negedge clk);
        wr(8'h29, 8'h80);
        rd(8'h2A, v); chk("R3 previous result", v, 8'hA0);
        wait_idle(600, cyc);
        rd(8'h2A, v); chk("R2 count lo P24", v, 8'hF0);
        rd(8'h2B, v); chk("R6 count hi P24", v, 8'h00);

        // R5 saturation with stalled oscillator
        wr(8'h29, 8'h80);
        repeat (60) @(negedge clk);
        stall = 1;
        repeat (70000) @(negedge clk);
        stall = 0;
        wait_idle(600, cyc);
        chk("R5 idle after stall", int'(busy), 0);
        rd(8'h2A, v); chk("R5 sat lo", v, 8'hFF);
        rd(8'h2B, v); chk("R5 sat hi", v, 8'hFF);

        // R6 count read-only
        wr(8'h2B, 8'h12);
        rd(8'h2B, v); chk("R6 write ignored", v, 8'hFF);
        prog_en = 1'b0;
        rd(8'h2B, v); chk("R6 pinsel untouched", v, 8'hE3);
        prog_en = 1'b1;

        repeat (5) @(negedge clk);
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule